// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching one entry from a page table in memory. Pages are 4 KB. The low twelve bits of the address are the byte offset within the page and pass through unchanged. The upper twenty bits are the virtual page number. The page number, scaled to the four-byte entry size, is added to a privileged table base register. The block issues one read at that address on a plain valid/ready request channel and waits for the read data on a response strobe.

The returned entry is 32 bits wide:
- bit 0 is the valid flag;
- bit 1 is the dirty flag;
- bits 31:12 are the physical page number.

When the entry is valid, the block joins the physical page number to the saved offset. When the entry is invalid, it reports a page fault. Either outcome appears as a one-cycle completion pulse.

Only supervisor mode may load the base register. A write attempted in user mode leaves the register unchanged and raises a one-cycle denial flag. The block takes one translation at a time and holds its request ready low from acceptance until the completion cycle.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `done`, `mem_req_valid` and `base_wr_denied` are 0.
- R2: Each accepted request causes exactly one memory read, at address base + (vaddr[31:12] << 2), modulo 2^32.
- R3: If bit 0 of the returned entry is 1, the completion carries `done_paddr` = {entry[31:12], vaddr[11:0]} and `done_fault` = 0.
- R4: If bit 0 of the returned entry is 0, the completion carries `done_fault` = 1, `done_paddr` = 0 and `done_dirty` = 0.
- R5: `done` is high for exactly one cycle per accepted request. It rises the cycle after the response strobe is sampled.
- R6: `req_ready` is 0 from the cycle after acceptance through the completion cycle. A request presented while `req_ready` is 0 is not accepted and causes no read and no completion.
- R7: A base write with `supervisor` = 1 takes effect for every request accepted after the write edge.
- R8: A base write with `supervisor` = 0 leaves the base unchanged. It raises `base_wr_denied` for exactly the one cycle after the write edge.
- R9: On a valid entry, `done_dirty` equals bit 1 of the entry.
- R10: `mem_req_valid` and `mem_req_addr` stay stable while `mem_req_ready` is 0.
- R11: The entry address is fixed when the request is accepted. A base write during a walk does not change the address of that walk's read.
- R12: The two low bits of the base register always read as zero, whatever value is written, so that entries stay word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker is idle and can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| base_wr_en | input | 1 | Base register write strobe |
| base_wr_data | input | 32 | New table base value |
| supervisor | input | 1 | 1 when the writer runs in supervisor mode |
| base_wr_denied | output | 1 | One-cycle flag for a rejected user-mode write |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Entry data strobe |
| mem_rsp_data | input | 32 | Returned table entry |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | 32 | Translated physical address, 0 on fault |
| done_fault | output | 1 | Page fault indication |
| done_dirty | output | 1 | Dirty flag of a valid entry |

## Verification
The hardest case to reach is a base register write that lands while a walk is stalled between acceptance and the memory handshake. This case separates an address latched at acceptance from one recomputed at issue. The bench memory model holds `mem_req_ready` low for a programmable number of cycles. During that window the bench performs a supervisor write and also presents spurious requests. It then checks that the read address still uses the old base, that no second read or completion appears, and that the next walk uses the new, low-bit-cleared base.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      PTW_IDLE  = 2'd0,
      PTW_ISSUE = 2'd1,
      PTW_WAIT  = 2'd2,
      PTW_DONE  = 2'd3
   } ptw_state_e;

   typedef struct packed {
      logic fault;
      logic dirty;
   } ptw_flags_t;

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
   parameter int          AW         = 32,
   parameter int          ALIGN_LSB  = 2,
   parameter logic [31:0] RESET_BASE = 32'h0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_data,
   input  logic          supervisor,
   output logic [AW-1:0] base_q,
   output logic          wr_denied
);

   localparam int KEEP_W = AW - ALIGN_LSB;

   generate
      if (ALIGN_LSB < 0 || ALIGN_LSB >= AW) begin : g_bad_align
         $error("ptw_base_reg: ALIGN_LSB out of range");
      end
   endgenerate

   logic wr_ok;
   assign wr_ok = wr_en & supervisor;

   generate
      if (ALIGN_LSB > 0) begin : g_aligned
         logic [KEEP_W-1:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_q <= RESET_BASE[AW-1:ALIGN_LSB];
            end else if (wr_ok) begin
               hi_q <= wr_data[AW-1:ALIGN_LSB];
            end
         end
         assign base_q = {hi_q, {ALIGN_LSB{1'b0}}};
      end else begin : g_full
         logic [AW-1:0] full_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               full_q <= RESET_BASE[AW-1:0];
            end else if (wr_ok) begin
               full_q <= wr_data;
            end
         end
         assign base_q = full_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_denied <= 1'b0;
      end else begin
         wr_denied <= wr_en & ~supervisor;
      end
   end

   // R8: a user-mode write leaves the base as it was
   p_user_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !supervisor) |=> $stable(base_q));

   // R8: the denial flag follows only a rejected write
   p_denied_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_denied) |-> ($past(wr_en) && !$past(supervisor)));

   // R12: aligned low bits never set
   generate
      if (ALIGN_LSB > 0) begin : g_chk_align
         p_align_r12: assert property (@(posedge clk) disable iff (!rst_n)
            base_q[ALIGN_LSB-1:0] == '0);
      end
   endgenerate

endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
   import ptw_pkg::*;
#(
   parameter int AW        = 32,
   parameter int PTE_W     = 32,
   parameter int OFFSET_W  = 12,
   parameter int VALID_BIT = 0,
   parameter int DIRTY_BIT = 1
) (
   input  logic [PTE_W-1:0]    pte,
   input  logic [OFFSET_W-1:0] offset,
   output logic [AW-1:0]       paddr,
   output ptw_flags_t          flags
);

   localparam int PPN_W     = AW - OFFSET_W;
   localparam int PTE_PPN_W = PTE_W - OFFSET_W;

   generate
      if (OFFSET_W <= 0 || OFFSET_W >= AW) begin : g_bad_off
         $error("ptw_entry_decode: OFFSET_W out of range");
      end
      if (VALID_BIT >= OFFSET_W || DIRTY_BIT >= OFFSET_W || VALID_BIT == DIRTY_BIT) begin : g_bad_bits
         $error("ptw_entry_decode: condition bits must sit below the page number and differ");
      end
   endgenerate

   logic             ent_valid;
   logic [PPN_W-1:0] ppn;

   assign ent_valid = pte[VALID_BIT];

   generate
      if (PTE_PPN_W >= PPN_W) begin : g_ppn_trunc
         assign ppn = pte[OFFSET_W +: PPN_W];
      end else begin : g_ppn_ext
         assign ppn = {{(PPN_W-PTE_PPN_W){1'b0}}, pte[PTE_W-1:OFFSET_W]};
      end
   endgenerate

   always_comb begin
      flags.fault = ~ent_valid;
      flags.dirty = ent_valid & pte[DIRTY_BIT];
      paddr       = ent_valid ? {ppn, offset} : '0;
   end

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
   import ptw_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   output logic          accept,
   input  logic [AW-1:0] entry_addr,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic [AW-1:0] mem_req_addr,
   input  logic          mem_rsp_valid,
   output logic          capture,
   output logic          done
);

   ptw_state_e    state_q, state_d;
   logic [AW-1:0] addr_q;

   assign req_ready     = (state_q == PTW_IDLE);
   assign accept        = req_valid & req_ready;
   assign mem_req_valid = (state_q == PTW_ISSUE);
   assign mem_req_addr  = addr_q;
   assign capture       = (state_q == PTW_WAIT) & mem_rsp_valid;
   assign done          = (state_q == PTW_DONE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PTW_IDLE:  if (req_valid)     state_d = PTW_ISSUE;
         PTW_ISSUE: if (mem_req_ready) state_d = PTW_WAIT;
         PTW_WAIT:  if (mem_rsp_valid) state_d = PTW_DONE;
         PTW_DONE:                     state_d = PTW_IDLE;
         default:                      state_d = PTW_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PTW_IDLE;
         addr_q  <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q <= entry_addr;
         end
      end
   end

   // R5: completion lasts a single cycle
   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5: completion only follows a sampled response
   p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(mem_rsp_valid));

   // R10: request held steady while memory stalls
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R6: no new acceptance while a walk is open
   p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid || done) |-> !req_ready);

   // R11: read address fixed from acceptance onward
   p_addr_fixed_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !$past(req_ready)) |-> $stable(mem_req_addr));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import ptw_pkg::*;
#(
   parameter int          AW         = 32,
   parameter int          PTE_W      = 32,
   parameter int          OFFSET_W   = 12,
   parameter int          VALID_BIT  = 0,
   parameter int          DIRTY_BIT  = 1,
   parameter logic [31:0] RESET_BASE = 32'h0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_vaddr,
   input  logic          base_wr_en,
   input  logic [AW-1:0] base_wr_data,
   input  logic          supervisor,
   output logic          base_wr_denied,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic [AW-1:0] mem_req_addr,
   input  logic          mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   output logic          done,
   output logic [AW-1:0] done_paddr,
   output logic          done_fault,
   output logic          done_dirty
);

   localparam int VPN_W       = AW - OFFSET_W;
   localparam int ENTRY_BYTES = PTE_W / 8;
   localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

   generate
      if (PTE_W % 8 != 0 || (1 << ENTRY_SHIFT) != ENTRY_BYTES) begin : g_bad_pte
         $error("pt_walker: PTE_W must be a power-of-two number of bytes");
      end
      if (AW > 32) begin : g_bad_aw
         $error("pt_walker: AW above 32 not supported by RESET_BASE");
      end
   endgenerate

   logic [AW-1:0]       base_q;
   logic [VPN_W-1:0]    vpn;
   logic [AW-1:0]       entry_addr;
   logic                accept;
   logic                capture;
   logic [OFFSET_W-1:0] offset_q;
   logic [AW-1:0]       dec_paddr;
   ptw_flags_t          dec_flags;
   logic [AW-1:0]       paddr_q;
   ptw_flags_t          flags_q;

   ptw_base_reg #(
      .AW         (AW),
      .ALIGN_LSB  (ENTRY_SHIFT),
      .RESET_BASE (RESET_BASE)
   ) u_base (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (base_wr_en),
      .wr_data    (base_wr_data),
      .supervisor (supervisor),
      .base_q     (base_q),
      .wr_denied  (base_wr_denied)
   );

   assign vpn        = req_vaddr[AW-1:OFFSET_W];
   assign entry_addr = base_q + (AW'(vpn) << ENTRY_SHIFT);

   ptw_fsm #(
      .AW (AW)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .accept        (accept),
      .entry_addr    (entry_addr),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .capture       (capture),
      .done          (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         offset_q <= '0;
      end else if (accept) begin
         offset_q <= req_vaddr[OFFSET_W-1:0];
      end
   end

   ptw_entry_decode #(
      .AW        (AW),
      .PTE_W     (PTE_W),
      .OFFSET_W  (OFFSET_W),
      .VALID_BIT (VALID_BIT),
      .DIRTY_BIT (DIRTY_BIT)
   ) u_dec (
      .pte    (mem_rsp_data),
      .offset (offset_q),
      .paddr  (dec_paddr),
      .flags  (dec_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         paddr_q <= '0;
         flags_q <= '0;
      end else if (capture) begin
         paddr_q <= dec_paddr;
         flags_q <= dec_flags;
      end
   end

   assign done_paddr = paddr_q;
   assign done_fault = flags_q.fault;
   assign done_dirty = flags_q.dirty;

   // R4: a faulting completion carries no address and no dirty flag
   p_fault_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_fault) |-> (done_paddr == '0 && !done_dirty));

   // R3: a successful completion keeps the offset captured at acceptance
   p_offset_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_fault) |-> (done_paddr[OFFSET_W-1:0] == offset_q));

endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        base_wr_en = 1'b0;
   logic [31:0] base_wr_data = '0;
   logic        supervisor = 1'b0;
   logic        base_wr_denied;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        done;
   logic [31:0] done_paddr;
   logic        done_fault;
   logic        done_dirty;

   always #2 clk = ~clk;

   pt_walker i_pt_walker (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_ready      (req_ready),
      .req_vaddr      (req_vaddr),
      .base_wr_en     (base_wr_en),
      .base_wr_data   (base_wr_data),
      .supervisor     (supervisor),
      .base_wr_denied (base_wr_denied),
      .mem_req_valid  (mem_req_valid),
      .mem_req_ready  (mem_req_ready),
      .mem_req_addr   (mem_req_addr),
      .mem_rsp_valid  (mem_rsp_valid),
      .mem_rsp_data   (mem_rsp_data),
      .done           (done),
      .done_paddr     (done_paddr),
      .done_fault     (done_fault),
      .done_dirty     (done_dirty)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [31:0] exp_base = 32'h0;
   int          stall = 0;
   int          lat = 0;
   int          reads = 0;
   int          dones = 0;

   logic [31:0] addr_q[$];
   logic [33:0] res_q[$];

   function automatic logic [31:0] pte_of(input logic [31:0] a);
      logic [19:0] ppn;
      ppn = a[21:2] ^ 20'h5A3C1;
      return {ppn, 10'h0, a[5], (a[4:2] != 3'b101)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // driver: queue expected read address and result, then present request
   task automatic walk(input logic [31:0] va);
      logic [31:0] ea, pte;
      while (!req_ready) @(negedge clk);
      ea  = exp_base + {10'b0, va[31:12], 2'b00};
      pte = pte_of(ea);
      addr_q.push_back(ea);
      if (pte[0]) res_q.push_back({1'b0, pte[1], pte[31:12], va[11:0]});
      else        res_q.push_back({1'b1, 1'b0, 32'h0});
      req_valid = 1'b1;
      req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R6 busy after accept", 64'(req_ready), 64'd0);
   endtask

   task automatic base_write(input logic [31:0] d, input bit sup);
      base_wr_en   = 1'b1;
      base_wr_data = d;
      supervisor   = sup;
      @(negedge clk);
      base_wr_en = 1'b0;
      supervisor = 1'b0;
      if (sup) exp_base = {d[31:2], 2'b00};
      chk(base_wr_denied == !sup, sup ? "R7 no denial" : "R8 denial flag",
          64'(base_wr_denied), 64'(!sup));
      @(negedge clk);
      chk(base_wr_denied == 1'b0, "R8 denial one cycle", 64'(base_wr_denied), 64'd0);
   endtask

   task automatic wait_idle();
      while (!(req_ready && addr_q.size() == 0 && res_q.size() == 0)) @(negedge clk);
      @(negedge clk);
   endtask

   // memory model
   initial begin
      logic [31:0] a, e;
      forever begin
         @(negedge clk);
         if (rst_n && mem_req_valid) begin
            a = mem_req_addr;
            for (int i = 0; i < stall; i++) begin
               @(negedge clk);
               if (!(mem_req_valid && mem_req_addr == a)) begin
                  chk(1'b0, "R10 hold during stall", 64'(mem_req_addr), 64'(a));
               end
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            reads++;
            if (addr_q.size() == 0) begin
               chk(1'b0, "R6 unexpected read", 64'(a), 64'd0);
            end else begin
               e = addr_q.pop_front();
               chk(a == e, "R2/R11 entry address", 64'(a), 64'(e));
            end
            chk(mem_req_valid == 1'b0, "R2 single read", 64'(mem_req_valid), 64'd0);
            for (int i = 0; i < lat; i++) @(negedge clk);
            mem_rsp_data  = pte_of(a);
            mem_rsp_valid = 1'b1;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = '0;
         end
      end
   end

   // monitor: compare completions against the scoreboard
   initial begin
      logic prev_done = 1'b0;
      logic [33:0] e;
      forever begin
         @(negedge clk);
         if (rst_n && done) begin
            dones++;
            chk(!prev_done, "R5 single-cycle done", 64'(prev_done), 64'd0);
            if (!prev_done) begin
               if (res_q.size() == 0) begin
                  chk(1'b0, "R6 unexpected done", 64'(done_paddr), 64'd0);
               end else begin
                  e = res_q.pop_front();
                  chk(done_fault == e[33], e[33] ? "R4 fault flag" : "R3 no fault",
                      64'(done_fault), 64'(e[33]));
                  chk(done_paddr == e[31:0], e[33] ? "R4 zero paddr" : "R3 paddr",
                      64'(done_paddr), 64'(e[31:0]));
                  chk(done_dirty == e[32], e[33] ? "R4 no dirty" : "R9 dirty",
                      64'(done_dirty), 64'(e[32]));
               end
            end
         end
         prev_done = rst_n & done;
      end
   end

   // watchdog
   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
      chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
      chk(mem_req_valid == 1'b0, "R1 mem idle", 64'(mem_req_valid), 64'd0);
      chk(base_wr_denied == 1'b0, "R1 denied", 64'(base_wr_denied), 64'd0);

      // R7 supervisor load
      base_write(32'h0010_0000, 1'b1);
      stall = 0; lat = 0;
      walk(32'h0000_3ABC);          // valid entry, R3
      wait_idle();
      walk(32'h0000_5123);          // bits[4:2]=101 -> fault, R4
      wait_idle();
      stall = 2; lat = 3;
      walk(32'hFFFF_FFFF);          // top page, R2 and R3
      wait_idle();
      walk(32'h0000_8FFF);          // dirty via address bit 5, R9
      wait_idle();

      // R8 user write ignored: next walk still uses old base
      base_write(32'hDEAD_0000, 1'b0);
      walk(32'h0001_2000);
      wait_idle();

      // R12 low base bits dropped
      base_write(32'h0020_0003, 1'b1);
      walk(32'h0000_D001);
      wait_idle();

      // R11 and R6: write base and present stray requests while stalled
      stall = 6; lat = 1;
      walk(32'h0004_2345);
      base_write(32'h0030_0000, 1'b1);
      req_valid = 1'b1;
      req_vaddr = 32'h7777_7777;
      @(negedge clk);
      chk(req_ready == 1'b0, "R6 stray request held off", 64'(req_ready), 64'd0);
      req_valid = 1'b0;
      wait_idle();
      stall = 0; lat = 0;
      walk(32'h0004_2345);          // same VPN, new base
      wait_idle();
      walk(32'h0000_5ABC);          // fault under new base check
      wait_idle();

      repeat (5) @(negedge clk);
      chk(reads == 9, "R2 read count", 64'(reads), 64'd9);
      chk(dones == 9, "R5 done count", 64'(dones), 64'd9);
      summary();
   end

endmodule